// File: doc/BRIEF.md
# SD card SPI-mode responder

This block stands in for the card during bring-up of a host-side SD driver that talks to its card over SPI. It sits on the host's chip-select, serial clock and data-out lines. It oversamples them with a fast system clock, gathers 6-byte command frames and answers on its own data-out line. It covers the commands a typical initialisation flow issues: card reset, interface-condition check, CRC enable/disable, the application-command prefix, the operating-condition poll and the OCR read. After initialisation, a single-block write runs with a start token, a 512-byte payload, a data-response byte and a busy period. A status command then closes the write.

The answer to the operating-condition poll stays "still idle" for a set number of attempts, so the host's retry loop is exercised. The length of the busy period is also set by a parameter. Payload bytes of a write leave the block on a valid/ready byte stream.

The SPI side cannot be stalled, so the stream has a one-byte holding register. A byte stays on `wr_data` with `wr_valid` high until the sink takes it with `wr_ready`. If the next payload byte completes while the held byte is still not taken, the new byte is discarded and the held byte is kept. A sink that keeps `wr_ready` high loses nothing.

Top module: `sd_spi_responder`

## Requirements
- R1: SPI mode 0. Incoming bits are taken on rising `sclk` edges, `miso` changes only on falling `sclk` edges (or when `cs_n` rises), and bytes travel MSB first. Byte boundaries count from the falling edge of `cs_n`.
- R2: A frame opens only on a received byte whose two top bits are `01`; its low six bits are the command index. Any other byte seen while hunting (such as 0xFF filler or 0x00) is ignored.
- R3: After the sixth frame byte, `miso` stays 1 for exactly one byte time (8 `sclk` cycles), and the first response byte follows directly.
- R4: Index 0 returns the single byte 0x01, puts the card back into the idle state and clears the operating-condition attempt count.
- R5: Index 8 with argument 0x000001AA returns five bytes: R1, 0x00, 0x00, 0x01, 0xAA. Any other argument returns R1 with the illegal-command bit (bit 2) set.
- R6: Index 59 and index 55 each return one R1 byte whose bit 0 is the idle flag and whose other bits are 0.
- R7: Index 41 directly after index 55 returns 0x01 for the first ACMD_WAIT attempts, then 0x00, and at that point the idle flag clears. Index 41 without the prefix is illegal.
- R8: Index 58 returns five bytes: R1, 0xC0, 0xFF, 0x80, 0x00 (capacity bit set).
- R9: Index 24 outside the idle state returns 0x00. The block then skips bytes until 0xFE, sends the following 512 bytes out on the stream in order, ignores two CRC bytes and answers with the data response 0xE5 (low five bits 00101).
- R10: The `sclk` cycle after the data response starts a busy period. In it `miso` is 0 for exactly BUSY_CLKS `sclk` cycles, then returns to 1.
- R11: Index 13 returns two bytes: R1 and 0x00.
- R12: Any other index, or index 24 while idle, returns one R1 byte with bit 2 set, and no data phase follows.
- R13: While `cs_n` is high, `miso` is 1 and frame assembly restarts. Once `cs_n` falls again, a partial frame has no effect on the next complete frame.
- R14: A payload byte is held on `wr_data` with `wr_valid` high until `wr_ready` takes it. A payload byte that completes while the previous one is still held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the `sclk` rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idles low |
| mosi | input | 1 | Host-to-card serial data |
| miso | output | 1 | Card-to-host serial data, idles high |
| wr_valid | output | 1 | A payload byte is being held |
| wr_data | output | 8 | Held payload byte |
| wr_ready | input | 1 | Sink takes the held byte this cycle |

## Verification
The bench builds the block with its defaults: ACMD_WAIT of 2, BUSY_CLKS of 20 and a 512-byte block. With an attempt count of 2, the change from the "idle" answer to the "ready" answer shows up on the third poll, and the bench checks each step of that sequence. A busy period of 20 cycles lasts longer than two whole bytes and ends inside the third byte, so the bench checks both the exact length of the busy period and the release part-way through a byte. A full 512-byte block is cheap enough to run twice: once with a sink that is always ready, and once with `wr_ready` held low for the whole block to show the drop rule.

// File: rtl/sdr_pkg.sv
`timescale 1ns/1ps
package sdr_pkg;
  localparam int SDR_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_HUNT, ST_GAP, ST_RESP, ST_TOKEN, ST_DATA, ST_DRESP, ST_BUSY
  } sdr_state_e;

  localparam logic [5:0] SDR_CMD_RESET  = 6'd0;
  localparam logic [5:0] SDR_CMD_IFCOND = 6'd8;
  localparam logic [5:0] SDR_CMD_STATUS = 6'd13;
  localparam logic [5:0] SDR_CMD_WRITE  = 6'd24;
  localparam logic [5:0] SDR_CMD_OPCOND = 6'd41;
  localparam logic [5:0] SDR_CMD_APPPFX = 6'd55;
  localparam logic [5:0] SDR_CMD_OCR    = 6'd58;
  localparam logic [5:0] SDR_CMD_CRCOPT = 6'd59;

  localparam logic [7:0]  SDR_FILL        = 8'hFF;
  localparam logic [7:0]  SDR_TOKEN_START = 8'hFE;
  localparam logic [7:0]  SDR_DRESP_OK    = 8'hE5;
  localparam logic [7:0]  SDR_R1_ILLEGAL  = 8'h04;
  localparam logic [31:0] SDR_IFCOND_ECHO = 32'h0000_01AA;
  localparam logic [31:0] SDR_OCR_VAL     = 32'hC0FF_8000;
endpackage

// File: rtl/sdr_pin_sync.sv
`timescale 1ns/1ps
module sdr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic sclk_in,
  input  logic mosi_in,
  output logic cs_hi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mo_p;
  logic [STAGES:0]   ck_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      mo_p <= '1;
      ck_p <= '0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_n_in};
      mo_p <= {mo_p[STAGES-2:0], mosi_in};
      ck_p <= {ck_p[STAGES-1:0], sclk_in};
    end
  end

  assign cs_hi     = cs_p[STAGES-1];
  assign mosi_s    = mo_p[STAGES-1];
  assign sclk_rise =  ck_p[STAGES-1] & ~ck_p[STAGES] & ~cs_hi;
  assign sclk_fall = ~ck_p[STAGES-1] &  ck_p[STAGES] & ~cs_hi;
endmodule

// File: rtl/sdr_byte_port.sv
`timescale 1ns/1ps
module sdr_byte_port
  import sdr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_hi,
  input  logic                  sclk_rise,
  input  logic                  sclk_fall,
  input  logic                  mosi_s,
  input  logic [SDR_BYTE_W-1:0] tx_next,
  input  logic                  hold_low,
  output logic                  byte_done,
  output logic [SDR_BYTE_W-1:0] rx_byte,
  output logic                  miso_q
);
  localparam int BCW = $clog2(SDR_BYTE_W);

  logic [BCW-1:0]        bit_q;
  logic [SDR_BYTE_W-1:0] rx_q;
  logic [SDR_BYTE_W-1:0] tx_q;
  logic                  done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '1;
      miso_q <= 1'b1;
      done_q <= 1'b0;
    end else if (cs_hi) begin
      bit_q  <= '0;
      tx_q   <= '1;
      miso_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= sclk_rise && (bit_q == BCW'(SDR_BYTE_W - 1));
      if (sclk_rise) begin
        rx_q  <= {rx_q[SDR_BYTE_W-2:0], mosi_s};
        bit_q <= bit_q + 1'b1;
      end
      if (sclk_fall) begin
        if (bit_q == '0) begin
          miso_q <= tx_next[SDR_BYTE_W-1] & ~hold_low;
          tx_q   <= {tx_next[SDR_BYTE_W-2:0], 1'b1};
        end else begin
          miso_q <= tx_q[SDR_BYTE_W-1] & ~hold_low;
          tx_q   <= {tx_q[SDR_BYTE_W-2:0], 1'b1};
        end
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;

  // R1
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(sclk_fall | cs_hi));

  // R10
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_low && sclk_fall) |=> !miso_q);
endmodule

// File: rtl/sdr_cmd_engine.sv
`timescale 1ns/1ps
module sdr_cmd_engine
  import sdr_pkg::*;
#(
  parameter int ACMD_WAIT   = 2,
  parameter int BUSY_CLKS   = 20,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_hi,
  input  logic                  sclk_fall,
  input  logic                  byte_done,
  input  logic [SDR_BYTE_W-1:0] rx_byte,
  output logic [SDR_BYTE_W-1:0] tx_next,
  output logic                  hold_low,
  output logic                  push_stb,
  output logic [SDR_BYTE_W-1:0] push_data
);
  localparam int AW  = $clog2(ACMD_WAIT + 2);
  localparam int BW  = $clog2(BUSY_CLKS + 1);
  localparam int DW  = $clog2(BLOCK_BYTES + 2);
  localparam int RSP = 5 * SDR_BYTE_W;

  sdr_state_e state_q;
  logic [2:0]            frame_q;
  logic [5:0]            cmd_q;
  logic [31:0]           arg_q;
  logic [RSP-1:0]        resp_q;
  logic [2:0]            len_q;
  logic [2:0]            rem_q;
  logic                  token_q;
  logic                  idle_q;
  logic                  app_q;
  logic [AW-1:0]         acmd_q;
  logic [DW-1:0]         data_q;
  logic [BW-1:0]         busy_q;
  logic [SDR_BYTE_W-1:0] tx_q;

  logic [SDR_BYTE_W-1:0] r1;
  logic [RSP-1:0]        d_resp;
  logic [2:0]            d_len;
  logic                  d_token;
  logic                  d_idle;
  logic [AW-1:0]         d_acmd;

  always_comb begin
    r1      = {7'b0, idle_q};
    d_resp  = {r1 | SDR_R1_ILLEGAL, 32'h0};
    d_len   = 3'd1;
    d_token = 1'b0;
    d_idle  = idle_q;
    d_acmd  = acmd_q;
    case (cmd_q)
      SDR_CMD_RESET: begin
        d_resp = {8'h01, 32'h0};
        d_idle = 1'b1;
        d_acmd = '0;
      end
      SDR_CMD_IFCOND:
        if (arg_q == SDR_IFCOND_ECHO) begin
          d_resp = {r1, SDR_IFCOND_ECHO};
          d_len  = 3'd5;
        end
      SDR_CMD_CRCOPT, SDR_CMD_APPPFX: d_resp = {r1, 32'h0};
      SDR_CMD_OPCOND:
        if (app_q) begin
          if (acmd_q < AW'(ACMD_WAIT)) begin
            d_resp = {8'h01, 32'h0};
            d_acmd = acmd_q + 1'b1;
          end else begin
            d_resp = '0;
            d_idle = 1'b0;
          end
        end
      SDR_CMD_OCR: begin
        d_resp = {r1, SDR_OCR_VAL};
        d_len  = 3'd5;
      end
      SDR_CMD_WRITE:
        if (!idle_q) begin
          d_resp  = '0;
          d_token = 1'b1;
        end
      SDR_CMD_STATUS: begin
        d_resp = {r1, 32'h0};
        d_len  = 3'd2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      frame_q <= '0;
      cmd_q   <= '0;
      arg_q   <= '0;
      resp_q  <= '0;
      len_q   <= 3'd1;
      rem_q   <= '0;
      token_q <= 1'b0;
      idle_q  <= 1'b1;
      app_q   <= 1'b0;
      acmd_q  <= '0;
      data_q  <= '0;
      busy_q  <= '0;
      tx_q    <= SDR_FILL;
    end else if (cs_hi) begin
      state_q <= ST_HUNT;
      frame_q <= '0;
      tx_q    <= SDR_FILL;
    end else begin
      case (state_q)
        ST_HUNT:
          if (byte_done) begin
            if (frame_q == 3'd0) begin
              if (rx_byte[7:6] == 2'b01) begin
                cmd_q   <= rx_byte[5:0];
                frame_q <= 3'd1;
              end
            end else if (frame_q == 3'd5) begin
              frame_q <= '0;
              state_q <= ST_GAP;
              resp_q  <= d_resp;
              len_q   <= d_len;
              token_q <= d_token;
              idle_q  <= d_idle;
              acmd_q  <= d_acmd;
              app_q   <= (cmd_q == SDR_CMD_APPPFX);
            end else begin
              arg_q   <= {arg_q[23:0], rx_byte};
              frame_q <= frame_q + 1'b1;
            end
          end
        ST_GAP:
          if (byte_done) begin
            tx_q    <= resp_q[RSP-1 -: SDR_BYTE_W];
            resp_q  <= resp_q << SDR_BYTE_W;
            rem_q   <= len_q;
            state_q <= ST_RESP;
          end
        ST_RESP:
          if (byte_done) begin
            if (rem_q == 3'd1) begin
              tx_q    <= SDR_FILL;
              state_q <= token_q ? ST_TOKEN : ST_HUNT;
            end else begin
              tx_q   <= resp_q[RSP-1 -: SDR_BYTE_W];
              resp_q <= resp_q << SDR_BYTE_W;
              rem_q  <= rem_q - 1'b1;
            end
          end
        ST_TOKEN:
          if (byte_done && rx_byte == SDR_TOKEN_START) begin
            data_q  <= '0;
            state_q <= ST_DATA;
          end
        ST_DATA:
          if (byte_done) begin
            data_q <= data_q + 1'b1;
            if (data_q == DW'(BLOCK_BYTES + 1)) begin
              tx_q    <= SDR_DRESP_OK;
              state_q <= ST_DRESP;
            end
          end
        ST_DRESP:
          if (byte_done) begin
            tx_q    <= SDR_FILL;
            busy_q  <= BW'(BUSY_CLKS);
            state_q <= ST_BUSY;
          end
        ST_BUSY:
          if (sclk_fall) begin
            busy_q <= busy_q - 1'b1;
            if (busy_q == BW'(1)) state_q <= ST_HUNT;
          end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign tx_next   = tx_q;
  assign hold_low  = (state_q == ST_BUSY);
  assign push_stb  = (state_q == ST_DATA) && byte_done && (data_q < DW'(BLOCK_BYTES));
  assign push_data = rx_byte;

  // R13
  cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (state_q == ST_HUNT && frame_q == 3'd0));

  // R10
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> (busy_q != '0));
endmodule

// File: rtl/sdr_wr_stream.sv
`timescale 1ns/1ps
module sdr_wr_stream
  import sdr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_stb,
  input  logic [SDR_BYTE_W-1:0] push_data,
  output logic                  wr_valid,
  output logic [SDR_BYTE_W-1:0] wr_data,
  input  logic                  wr_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (push_stb && (!wr_valid || wr_ready)) begin
      wr_valid <= 1'b1;
      wr_data  <= push_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R14
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
endmodule

// File: rtl/sd_spi_responder.sv
`timescale 1ns/1ps
module sd_spi_responder
  import sdr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACMD_WAIT   = 2,
  parameter int BUSY_CLKS   = 20,
  parameter int BLOCK_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  mosi,
  output logic                  miso,
  output logic                  wr_valid,
  output logic [SDR_BYTE_W-1:0] wr_data,
  input  logic                  wr_ready
);
  logic                  cs_hi, sclk_rise, sclk_fall, mosi_s;
  logic                  byte_done, hold_low, push_stb;
  logic [SDR_BYTE_W-1:0] rx_byte, tx_next, push_data;

  sdr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .mosi_in(mosi),
    .cs_hi(cs_hi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  sdr_byte_port u_port (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .tx_next(tx_next),
    .hold_low(hold_low), .byte_done(byte_done), .rx_byte(rx_byte), .miso_q(miso)
  );

  sdr_cmd_engine #(
    .ACMD_WAIT(ACMD_WAIT), .BUSY_CLKS(BUSY_CLKS), .BLOCK_BYTES(BLOCK_BYTES)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_next(tx_next),
    .hold_low(hold_low), .push_stb(push_stb), .push_data(push_data)
  );

  sdr_wr_stream u_stream (
    .clk(clk), .rst_n(rst_n), .push_stb(push_stb), .push_data(push_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );
endmodule

// File: tb/sd_spi_responder_bench.sv
`timescale 1ns/1ps
module sd_spi_responder_bench;
  localparam int HALF      = 5;
  localparam int BUSY_CLKS = 20;
  localparam int BLK       = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b1;
  logic wr_ready = 1'b1;
  logic miso, wr_valid;
  logic [7:0] wr_data;

  int total = 0;
  int bad = 0;
  int sink_cnt = 0;
  int sink_bad = 0;
  logic [7:0] sink_last = 8'h00;
  bit block1 = 1'b0;

  always #10 clk = ~clk;

  sd_spi_responder u_sd_spi_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  // vector fields: [80:75] index, [74:43] argument, [42:40] length, [39:0] expected (left aligned), req in separate table
  localparam logic [80:0] VEC [16] = '{
    {6'd0,  32'h0000_0000, 3'd1, 40'h01_0000_0000},  // R4 reset
    {6'd24, 32'h0000_0000, 3'd1, 40'h05_0000_0000},  // R12 write while idle
    {6'd8,  32'h0000_01AA, 3'd5, 40'h01_0000_01AA},  // R5 echo
    {6'd8,  32'h0000_0155, 3'd1, 40'h05_0000_0000},  // R5 wrong argument
    {6'd41, 32'h4000_0000, 3'd1, 40'h05_0000_0000},  // R7 no prefix
    {6'd59, 32'h0000_0000, 3'd1, 40'h01_0000_0000},  // R6
    {6'd55, 32'h0000_0000, 3'd1, 40'h01_0000_0000},  // R6
    {6'd41, 32'h4000_0000, 3'd1, 40'h01_0000_0000},  // R7 attempt 1
    {6'd55, 32'h0000_0000, 3'd1, 40'h01_0000_0000},  // R6
    {6'd41, 32'h4000_0000, 3'd1, 40'h01_0000_0000},  // R7 attempt 2
    {6'd55, 32'h0000_0000, 3'd1, 40'h01_0000_0000},  // R6
    {6'd41, 32'h4000_0000, 3'd1, 40'h00_0000_0000},  // R7 ready
    {6'd55, 32'h0000_0000, 3'd1, 40'h00_0000_0000},  // R6 idle flag now 0
    {6'd58, 32'h0000_0000, 3'd5, 40'h00_C0FF_8000},  // R8
    {6'd13, 32'h0000_0000, 3'd2, 40'h00_0000_0000},  // R11
    {6'd17, 32'h0000_0000, 3'd1, 40'h04_0000_0000}   // R12 unsupported index
  };
  localparam int VREQ [16] = '{4, 12, 5, 5, 7, 6, 6, 7, 6, 7, 6, 7, 6, 8, 11, 12};

  function automatic logic [7:0] pat1(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction
  function automatic logic [7:0] pat2(input int i);
    return 8'((i * 13 + 8'h5A) & 8'hFF);
  endfunction

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: got %0h expected %0h", req, act, exp);
    end
  endtask

  // R1: host drives mosi while sclk is low, samples miso just before the rising edge, MSB first
  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input int len,
                        input logic [39:0] exp, input int req);
    logic [7:0]  rx;
    logic [39:0] got;
    got = '0;
    spi_byte({2'b01, idx}, rx);
    for (int k = 3; k >= 0; k--) spi_byte(arg[k*8 +: 8], rx);
    spi_byte(8'h95, rx);
    spi_byte(8'hFF, rx);
    chk(3, {56'h0, rx}, 64'hFF);  // R3 one filler byte of ones
    for (int k = 0; k < len; k++) begin
      spi_byte(8'hFF, rx);
      got[39 - 8*k -: 8] = rx;
    end
    chk(req, {24'h0, got}, {24'h0, exp});
  endtask

  task automatic count_busy(output int zeros);
    logic [7:0] b;
    bit seen;
    seen = 1'b0;
    zeros = 0;
    for (int k = 0; k < 8 && !seen; k++) begin
      spi_byte(8'hFF, b);
      for (int j = 7; j >= 0; j--) begin
        if (!seen) begin
          if (b[j] == 1'b0) zeros++;
          else seen = 1'b1;
        end
      end
    end
  endtask

  task automatic write_block(input bit second);
    logic [7:0] rx;
    int zeros;
    spi_byte(8'hFF, rx);
    spi_byte(8'hFE, rx);
    for (int i = 0; i < BLK; i++) spi_byte(second ? pat2(i) : pat1(i), rx);
    spi_byte(8'h12, rx);
    spi_byte(8'h34, rx);
    spi_byte(8'hFF, rx);
    chk(9, {56'h0, rx}, 64'hE5);  // R9 data response
    count_busy(zeros);
    chk(10, zeros, BUSY_CLKS);    // R10 busy length
  endtask

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      if (block1 && wr_data !== pat1(sink_cnt)) sink_bad++;
      sink_last = wr_data;
      sink_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(13, {63'h0, miso}, 64'h1);      // R13 reset: miso high
    chk(14, {63'h0, wr_valid}, 64'h0);  // R14 reset: nothing held
    cs_n = 1'b0;
    repeat (4) @(negedge clk);

    // R2: filler and a byte with wrong top bits before the first frame
    spi_byte(8'hFF, rx);
    spi_byte(8'h00, rx);
    spi_byte(8'hFF, rx);
    chk(2, {56'h0, rx}, 64'hFF);

    for (int i = 0; i < 16; i++)
      do_cmd(VEC[i][80:75], VEC[i][74:43], int'(VEC[i][42:40]), VEC[i][39:0], VREQ[i]);

    // R9: block write, sink always ready
    block1 = 1'b1;
    do_cmd(6'd24, 32'h0000_0010, 1, 40'h00_0000_0000, 9);
    write_block(1'b0);
    block1 = 1'b0;
    chk(9, sink_cnt, BLK);
    chk(9, sink_bad, 0);
    do_cmd(6'd13, 32'h0, 2, 40'h0, 11);  // R11 status after write

    // R14: second block with the sink stalled
    @(posedge clk); #3 wr_ready = 1'b0;
    do_cmd(6'd24, 32'h0000_0011, 1, 40'h00_0000_0000, 9);
    write_block(1'b1);
    chk(14, sink_cnt, BLK);
    chk(14, {63'h0, wr_valid}, 64'h1);
    chk(14, {56'h0, wr_data}, {56'h0, pat2(0)});
    @(posedge clk); #3 wr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(14, sink_cnt, BLK + 1);
    chk(14, {56'h0, sink_last}, {56'h0, pat2(0)});
    chk(14, {63'h0, wr_valid}, 64'h0);

    // R13: abandoned partial frame across a chip-select pulse
    spi_byte(8'h40, rx);
    spi_byte(8'h00, rx);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(13, {63'h0, miso}, 64'h1);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    do_cmd(6'd0, 32'h0, 1, 40'h01_0000_0000, 13);
    // R4: reset restores idle flag and the attempt count
    do_cmd(6'd55, 32'h0, 1, 40'h01_0000_0000, 4);
    do_cmd(6'd41, 32'h4000_0000, 1, 40'h01_0000_0000, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule